// File: doc/BRIEF.md
# Word-Framed SPI Register Access Master

This block lets on-chip logic read and write the registers of an external peripheral over SPI. The peripheral is addressed in 32-bit words. The user presents one request at a time. A request gives a direction, a starting word address and a word count. The block then runs one frame with the select line held low. The frame opens with a packed 32-bit command word. For a write, the data words come next. For a read, the reply words come next.

SCLK comes from the system clock through a half-period divider. Its idle level is low. The block changes its serial output on falling edges and samples the peripheral's reply on rising edges. Select goes low half an SCLK period before the first rising edge. It goes high again half a period after the last falling edge. The block asks for each write word with a one-cycle take strobe. Each reply word is presented on a parallel bus with a one-cycle valid pulse.

Top module: `spiw_master`

## Requirements
- R1: The command word carries the direction in bit 31 (1 = write, 0 = read), the word count in bits 30:25 and the word address in bits 24:4, with bits 3:0 zero. It is sent most significant bit first, as the first 32 bits of the frame.
- R2: A transfer of N words has exactly 32 × (1 + N) SCLK rising edges while `csN` is low.
- R3: SCLK is low while `csN` is high. `sdi` changes only on falling edges of SCLK, so it holds steady while SCLK is high.
- R4: `csN` falls exactly HALF_DIV system clocks before the first SCLK rising edge. It rises exactly HALF_DIV system clocks after the last SCLK falling edge.
- R5: Each reply word is built from the `sdo` bits sampled on 32 rising edges, first bit most significant. Reply words appear on `rdData` in address order, each with a `rdValid` pulse one cycle long. During the command word, `sdo` has no effect.
- R6: On a write, the N data words follow the command directly, each sent most significant bit first. `wrTake` pulses once for each word, and `wrData` is taken in that same cycle. `rdValid` stays low.
- R7: `busy` goes high in the cycle after a request is accepted. It stays high until `csN` has returned high. Requests made while `busy` is high are ignored.
- R8: A request with a word count of zero is ignored: no frame starts and `busy` stays low.
- R9: Each SCLK half period lasts HALF_DIV system clocks, so `busy` stays high for HALF_DIV × (1 + 64 × (1 + N)) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Starting word address |
| reqCount | input | CNT_W | Number of data words |
| wrData | input | WORD_W | Write word being taken |
| wrTake | output | 1 | Pulse: `wrData` is taken in this cycle |
| busy | output | 1 | A frame is in progress |
| rdData | output | WORD_W | Received reply word |
| rdValid | output | 1 | One-cycle pulse marking a new `rdData` |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low peripheral select |
| sdi | output | 1 | Serial data toward the peripheral |
| sdo | input | 1 | Serial data from the peripheral |

## Verification
Reads are swept over word counts 1 to 4, at address zero, at address one, at a mid-range address and at the highest address. This separates errors in the address field from errors in the count field and in bit placement. The peripheral model drives alternating junk on `sdo` during the command and returns address-dependent words after it, so a reply taken one bit or one word early shows up. Writes carry distinct data words, which exposes a wrong word order or a wrong take timing. Zero-count requests and requests made while busy check that nothing starts and that the running frame is left unchanged.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD
  } spiw_state_t;

  typedef struct packed {
    logic loadCmd;   // latch request into the command word
    logic shiftOut;  // falling edge: advance serial output
    logic loadWord;  // falling edge at word boundary of a write: take wrData
    logic sampleIn;  // rising edge: shift sdo in
    logic emitWord;  // rising edge of the last bit of a reply word
  } spiw_strobe_t;

endpackage

// File: rtl/spiw_ctrl.sv
module spiw_ctrl
  import spiw_pkg::*;
#(
  parameter int HALF_DIV = 12,
  parameter int CNT_W    = 6,
  parameter int WORD_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] reqCount,
  output logic             busy,
  output logic             csN,
  output logic             sclk,
  output spiw_strobe_t     stb
);

  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BCW = $clog2(WORD_W);
  localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_DIV - 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(WORD_W - 1);

  spiw_state_t      state;
  logic [HCW-1:0]   halfCnt;
  logic [BCW-1:0]   bitCnt;
  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W-1:0] lastWordQ;
  logic             isWriteQ;

  logic start, halfEnd, wordEnd, lastBit;

  always_comb begin
    start   = (state == ST_IDLE) && reqValid && (reqCount != '0);
    halfEnd = (halfCnt == HALF_LAST);
    wordEnd = (bitCnt == BIT_LAST);
    lastBit = wordEnd && (wordIdx == lastWordQ);

    stb          = '0;
    stb.loadCmd  = start;
    stb.sampleIn = halfEnd && ((state == ST_SETUP) || (state == ST_LOW));
    stb.shiftOut = halfEnd && (state == ST_HIGH) && !lastBit;
    stb.loadWord = stb.shiftOut && wordEnd && isWriteQ;
    stb.emitWord = stb.sampleIn && !isWriteQ && (wordIdx != '0) && wordEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      bitCnt    <= '0;
      wordIdx   <= '0;
      lastWordQ <= '0;
      isWriteQ  <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
    end else begin
      halfCnt <= halfEnd ? '0 : halfCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          halfCnt <= '0;
          if (start) begin
            state     <= ST_SETUP;
            csN       <= 1'b0;
            bitCnt    <= '0;
            wordIdx   <= '0;
            lastWordQ <= reqCount;
            isWriteQ  <= reqWrite;
          end
        end
        ST_SETUP, ST_LOW: begin
          if (halfEnd) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            sclk <= 1'b0;
            if (lastBit) begin
              state <= ST_HOLD;
            end else begin
              state  <= ST_LOW;
              bitCnt <= bitCnt + 1'b1;
              if (wordEnd) wordIdx <= wordIdx + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (halfEnd) begin
            csN   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: frame parameters cannot be disturbed by requests arriving mid-frame
  a_r7_frame_locked: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(isWriteQ) && $stable(lastWordQ)));

  // R3: serial clock idles low whenever select is released
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

endmodule

// File: rtl/spiw_dp.sv
module spiw_dp
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiw_strobe_t      stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdo,
  output logic              sdi,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  localparam int PAD_W = WORD_W - 1 - CNT_W - ADDR_W;

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign rxNext = {rxShift[WORD_W-2:0], sdo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.loadCmd) begin
      txShift <= {reqWrite, reqCount, reqAddr, {PAD_W{1'b0}}};
    end else if (stb.shiftOut) begin
      txShift <= stb.loadWord ? wrData : {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.emitWord;
      if (stb.sampleIn) rxShift <= rxNext;
      if (stb.emitWord) rdData <= rxNext;
    end
  end

  assign sdi = txShift[WORD_W-1];

  // R5: a reply word is flagged for exactly one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R6: write data is never taken on the same edge as reply capture
  a_r6_take_not_emit: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWord |-> !stb.emitWord);

endmodule

// File: rtl/spiw_master.sv
module spiw_master
  import spiw_pkg::*;
#(
  parameter int HALF_DIV = 12,
  parameter int ADDR_W   = 21,
  parameter int CNT_W    = 6,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [WORD_W-1:0] wrData,
  output logic              wrTake,
  output logic              busy,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              sclk,
  output logic              csN,
  output logic              sdi,
  input  logic              sdo
);

  spiw_strobe_t stb;

  spiw_ctrl #(
    .HALF_DIV (HALF_DIV),
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqCount (reqCount),
    .busy     (busy),
    .csN      (csN),
    .sclk     (sclk),
    .stb      (stb)
  );

  spiw_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqCount (reqCount),
    .wrData   (wrData),
    .sdo      (sdo),
    .sdi      (sdi),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign wrTake = stb.loadWord;

  // R3: serial output holds while SCLK is high
  a_r3_sdi_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdi));

  // R6: write words are only taken inside a frame, at the end of a high phase
  a_r6_take_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (!csN && sclk));

  // R4: select is released only after SCLK has already been low
  a_r4_release_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (!sclk && $past(!sclk)));

endmodule

// File: tb/spiw_master_test.sv
module spiw_master_test;

  localparam int H  = 2;
  localparam int AW = 21;
  localparam int CW = 6;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [CW-1:0] reqCount = '0;
  logic [WW-1:0] wrData;
  logic          wrTake, busy, rdValid, sclk, csN, sdi;
  logic [WW-1:0] rdData;
  logic          sdo = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  spiw_master #(.HALF_DIV(H), .ADDR_W(AW), .CNT_W(CW), .WORD_W(WW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCount(reqCount), .wrData(wrData), .wrTake(wrTake),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .sclk(sclk), .csN(csN),
    .sdi(sdi), .sdo(sdo)
  );

  int total = 0;
  int bad = 0;

  // monitor state
  int          cyc = 0;
  int          busyCyc, riseCnt, rdCnt, takeCnt;
  int          csFallCyc, firstRiseCyc, lastFallCyc, csRiseCyc;
  logic        mosi [0:511];
  logic [WW-1:0] rdBuf [0:15];
  logic [WW-1:0] wrWords [0:15];
  int          wrIdx = 0;
  logic        prevSclk = 1'b0;
  logic        prevCsN = 1'b1;

  assign wrData = wrWords[wrIdx];

  function automatic logic [WW-1:0] replyWord(input logic [WW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [WW-1:0] frameWord(input int w);
    logic [WW-1:0] v = '0;
    for (int b = 0; b < WW; b++) v[WW-1-b] = mosi[w*WW + b];
    return v;
  endfunction

  function automatic logic sdoBit(input int c);
    logic [WW-1:0] cmd, a;
    if (c < WW) return c[0] ^ c[2];
    cmd = frameWord(0);
    a = {11'd0, cmd[24:4]} + WW'(c / WW - 1);
    return replyWord(a)[WW-1 - (c % WW)];
  endfunction

  always @(posedge clk) if (wrTake) wrIdx <= wrIdx + 1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy) busyCyc = busyCyc + 1;
    if (!csN && prevCsN) begin
      csFallCyc = cyc;
      sdo = sdoBit(0);
    end
    if (sclk && !prevSclk) begin
      if (riseCnt == 0) firstRiseCyc = cyc;
      mosi[riseCnt] = sdi;
      riseCnt = riseCnt + 1;
    end
    if (!sclk && prevSclk) begin
      lastFallCyc = cyc;
      sdo = sdoBit(riseCnt);
    end
    if (csN && !prevCsN) csRiseCyc = cyc;
    if (rdValid) begin
      rdBuf[rdCnt] = rdData;
      rdCnt = rdCnt + 1;
    end
    if (wrTake) takeCnt = takeCnt + 1;
    prevSclk = sclk;
    prevCsN = csN;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    busyCyc = 0; riseCnt = 0; rdCnt = 0; takeCnt = 0;
    csFallCyc = 0; firstRiseCyc = 0; lastFallCyc = 0; csRiseCyc = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(n < 20000, "R7 busy timeout", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic runXfer(input logic wr, input logic [AW-1:0] a, input int n, input logic poke);
    logic [WW-1:0] expCmd;
    int bits;
    @(negedge clk);
    clearMon();
    wrIdx = 0;
    for (int k = 0; k < n; k++) wrWords[k] = (32'h8000_0001 * (k + 3)) ^ {11'd0, a};
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqCount = CW'(n);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      reqValid = 1'b1; reqWrite = ~wr; reqAddr = ~a; reqCount = 6'd9;
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitIdle();
    bits = WW * (1 + n);
    expCmd = (WW'(wr) << 31) | (WW'(n) << 25) | (WW'(a) << 4);
    check(frameWord(0) == expCmd, "R1 command word", frameWord(0), expCmd);
    check(riseCnt == bits, "R2 rising edge count", riseCnt, bits);
    check(firstRiseCyc - csFallCyc == H, "R4 select setup", firstRiseCyc - csFallCyc, H);
    check(csRiseCyc - lastFallCyc == H, "R4 select hold", csRiseCyc - lastFallCyc, H);
    check(busyCyc == H * (1 + 2 * bits), "R9 busy length", busyCyc, H * (1 + 2 * bits));
    if (wr) begin
      check(takeCnt == n, "R6 take count", takeCnt, n);
      check(rdCnt == 0, "R6 no reply on write", rdCnt, 0);
      for (int k = 0; k < n; k++)
        check(frameWord(k + 1) == wrWords[k], "R6 write word", frameWord(k + 1), wrWords[k]);
    end else begin
      check(rdCnt == n, "R5 reply count", rdCnt, n);
      check(takeCnt == 0, "R5 no take on read", takeCnt, 0);
      for (int k = 0; k < n && k < 16; k++)
        check(rdBuf[k] == replyWord({11'd0, a} + WW'(k)), "R5 reply word",
              rdBuf[k], replyWord({11'd0, a} + WW'(k)));
    end
    check(csN == 1'b1 && sclk == 1'b0, "R3 idle after frame", {csN, sclk}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearMon();
    for (int k = 0; k < 16; k++) wrWords[k] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1, "R3 reset csN", csN, 1);
    check(sclk == 1'b0, "R3 reset sclk", sclk, 0);
    check(busy == 1'b0, "R7 reset busy", busy, 0);
    check(rdValid == 1'b0 && wrTake == 1'b0, "R5 reset strobes", {rdValid, wrTake}, 0);

    // R8: zero count ignored
    @(negedge clk);
    clearMon();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 21'h55; reqCount = '0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1 && riseCnt == 0, "R8 zero count ignored",
          {busy, csN, 8'(riseCnt)}, 10'h100);

    // reads: sweep addresses and counts
    for (int n = 1; n <= 4; n++) begin
      runXfer(1'b0, 21'h0, n, 1'b0);
      runXfer(1'b0, 21'h1, n, 1'b0);
      runXfer(1'b0, 21'h12345, n, 1'b0);
    end
    runXfer(1'b0, 21'h1FFFFF, 1, 1'b0);

    // writes
    for (int n = 1; n <= 3; n++) begin
      runXfer(1'b1, 21'h00007, n, 1'b0);
      runXfer(1'b1, 21'h1FFFF0, n, 1'b0);
    end

    // R7: requests while busy ignored
    runXfer(1'b0, 21'h0ABCD, 2, 1'b1);
    runXfer(1'b1, 21'h00100, 2, 1'b1);
    clearMon();
    repeat (20) @(negedge clk);
    check(riseCnt == 0 && busy == 0, "R7 no frame from busy request",
          riseCnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule